// File: doc/BRIEF.md
# Serial Boot Password Gate

This block sits behind a byte receiver in a serial boot loader and guards entry into the RAM-download path. It reads one command byte at a time. Only the RAM-transfer command opens the password path. For that command the block takes in a 12-byte password and then a checksum byte. It compares the password with a copy held in a small synchronous memory and returns one acknowledge byte that reports the result. When all checks succeed it also raises a one-cycle grant. Any other outcome sends the block back to waiting for a command.

Every response is a single byte, held on a valid/ready transmit handshake until the transmitter accepts it. Error responses carry the upper nibble of the command byte received before the current one. A synchronous-mode input disables receive-error checking, for links whose framing cannot produce such errors.

Top module: `boot_pw_gate`

## Requirements
- R1: After reset, tx_valid, grant and pw_rd are low, and the stored previous command is 0x00, so a first command received with an error is answered 0x08.
- R2: A command byte of 0x10 received without error is answered 0x10. The block then takes in 12 password bytes and one checksum byte.
- R3: A command byte received with rx_err high is answered with low nibble 0x8 and upper nibble equal to bits 7:4 of the previously received command byte.
- R4: Any command byte other than 0x10, received without error, is answered with low nibble 0x1 and upper nibble equal to bits 7:4 of the previously received command byte. Every received command byte, with or without error, becomes the new previous command.
- R5: While sync_mode is high, rx_err is ignored on both the command byte and the password bytes.
- R6: If the sum modulo 256 of the 12 password bytes and the checksum byte is not 0x00, the final answer is 0x11, provided no receive error was seen.
- R7: A receive error on any of the 13 bytes after the command makes the final answer 0x18. This takes priority over checksum and password failures.
- R8: Each password byte k (k = 0..11) is compared with stored byte k, read at pw_addr = k. Any mismatch, with a valid checksum, makes the final answer 0x11.
- R9: If all 12 stored bytes hold the same value and that value is not 0xFF, the final answer is 0x11 even when the received bytes match. An all-0xFF store is accepted.
- R10: When all checks pass, the final answer is 0x10 and grant is high for exactly one cycle, in the first cycle that this answer is on tx_data with tx_valid high.
- R11: An answer stays on tx_data with tx_valid high, unchanged, until tx_ready is sampled high. Bytes offered on rx_valid in the meantime are dropped.
- R12: After any final answer the block waits for a new command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | rx_data holds a new byte this cycle |
| rx_err | input | 1 | Receive error flag for this byte |
| sync_mode | input | 1 | Synchronous link: receive errors are ignored |
| tx_data | output | 8 | Acknowledge byte |
| tx_valid | output | 1 | Acknowledge pending |
| tx_ready | input | 1 | Transmitter takes the acknowledge |
| pw_addr | output | 4 | Stored-password byte index |
| pw_rd | output | 1 | Read strobe; data is returned one cycle later |
| pw_rdata | input | 8 | Stored-password byte |
| grant | output | 1 | One-cycle pulse on successful verification |

## Verification
The assertions check the handshake and timing rules on every cycle: a pending acknowledge holds steady until it is taken, no password read is issued while a response waits, grant lasts one cycle and always coincides with a 0x10 answer, and the byte index stays in range. The bench scenarios are the only way to show the protocol content. This covers the nibble carried over from the previous command, the order in which error sources take priority, the checksum arithmetic, byte-by-byte password comparison, the rule that rejects a store filled with one repeated value, and the effect of sync mode.

// File: rtl/boot_pw_gate.sv
module boot_pw_gate #(
  parameter int          PW_LEN  = 12,
  parameter logic [7:0]  CMD_RAM = 8'h10,
  parameter logic [7:0]  BLANK   = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] rx_data,
  input  logic       rx_valid,
  input  logic       rx_err,
  input  logic       sync_mode,
  output logic [7:0] tx_data,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic [$clog2(PW_LEN)-1:0] pw_addr,
  output logic       pw_rd,
  input  logic [7:0] pw_rdata,
  output logic       grant
);
  localparam int AW = $clog2(PW_LEN);
  localparam int IW = $clog2(PW_LEN + 1);
  localparam logic [IW-1:0] LAST = IW'(PW_LEN - 1);
  localparam logic [IW-1:0] TOP  = IW'(PW_LEN);

  typedef enum logic [1:0] {S_CMD, S_PW, S_SUM, S_CHK} st_t;

  st_t           st;
  logic [7:0]    prev_cmd, sum, cmp_byte, first;
  logic [IW-1:0] idx;
  logic          rxe, pwe, same, cmp_pend, cmp_first;

  wire take = rx_valid & ~tx_valid;
  wire bad  = rx_err & ~sync_mode;

  assign pw_rd   = take && (st == S_PW);
  assign pw_addr = idx[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_CMD; prev_cmd <= 8'h00; tx_valid <= 1'b0; tx_data <= 8'h00;
      grant <= 1'b0; idx <= '0; sum <= 8'h00; rxe <= 1'b0; pwe <= 1'b0;
      same <= 1'b1; first <= 8'h00; cmp_pend <= 1'b0; cmp_byte <= 8'h00;
      cmp_first <= 1'b0;
    end else begin
      grant    <= 1'b0;
      cmp_pend <= 1'b0;
      if (tx_valid && tx_ready) tx_valid <= 1'b0;

      if (cmp_pend) begin
        if (pw_rdata != cmp_byte) pwe <= 1'b1;
        if (cmp_first) first <= pw_rdata;
        else if (pw_rdata != first) same <= 1'b0;
      end

      case (st)
        S_CMD: if (take) begin
          prev_cmd <= rx_data;
          tx_valid <= 1'b1;
          idx <= '0; sum <= 8'h00; rxe <= 1'b0; pwe <= 1'b0; same <= 1'b1;
          if (bad)
            tx_data <= {prev_cmd[7:4], 4'h8};
          else if (rx_data == CMD_RAM) begin
            tx_data <= CMD_RAM;
            st <= S_PW;
          end else
            tx_data <= {prev_cmd[7:4], 4'h1};
        end
        S_PW: if (take) begin
          sum       <= sum + rx_data;
          rxe       <= rxe | bad;
          cmp_pend  <= 1'b1;
          cmp_byte  <= rx_data;
          cmp_first <= (idx == '0);
          idx       <= idx + 1'b1;
          if (idx == LAST) st <= S_SUM;
        end
        S_SUM: if (take) begin
          sum <= sum + rx_data;
          rxe <= rxe | bad;
          st  <= S_CHK;
        end
        default: begin
          tx_valid <= 1'b1;
          st  <= S_CMD;
          idx <= '0;
          same <= 1'b1;
          if (rxe)
            tx_data <= {CMD_RAM[7:4], 4'h8};
          else if (sum != 8'h00)
            tx_data <= {CMD_RAM[7:4], 4'h1};
          else if (pwe || (same && first != BLANK))
            tx_data <= {CMD_RAM[7:4], 4'h1};
          else begin
            tx_data <= CMD_RAM;
            grant <= 1'b1;
          end
        end
      endcase
    end
  end

  // R11
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R11
  no_read_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !pw_rd);

  // R10
  grant_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> tx_valid && tx_data == CMD_RAM);

  // R10
  grant_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !grant);

  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= TOP);
endmodule

// File: tb/boot_pw_gate_test.sv
module boot_pw_gate_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [7:0] rx_data = 0;
  logic rx_valid = 0, rx_err = 0, sync_mode = 0, tx_ready = 0;
  logic [7:0] tx_data, pw_rdata = 0;
  logic tx_valid, pw_rd, grant;
  logic [3:0] pw_addr;

  logic [7:0] mem [12];
  logic [7:0] rxpw [12];
  int checks = 0, errors = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_pw_gate uut (.clk, .rst_n, .rx_data, .rx_valid, .rx_err, .sync_mode,
    .tx_data, .tx_valid, .tx_ready, .pw_addr, .pw_rd, .pw_rdata, .grant);

  always @(posedge clk) if (pw_rd) pw_rdata <= mem[pw_addr];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input bit e);
    @(negedge clk);
    while (tx_valid) @(negedge clk);
    rx_data = b; rx_err = e; rx_valid = 1;
    @(negedge clk);
    rx_valid = 0; rx_err = 0;
  endtask

  task automatic get_ack(input logic [7:0] exp, input bit exp_grant, input string req);
    for (int i = 0; i < 50 && !tx_valid; i++) @(negedge clk);
    chk(tx_valid === 1'b1, {req, " ack present"}, {7'd0, tx_valid}, 8'h01);
    chk(tx_data === exp, {req, " ack value"}, tx_data, exp);
    chk(grant === exp_grant, {req, " grant"}, {7'd0, grant}, {7'd0, exp_grant});
    tx_ready = 1;
    @(negedge clk);
    tx_ready = 0;
  endtask

  task automatic body(input int err_at, input logic [7:0] delta);
    logic [7:0] s = 0;
    for (int i = 0; i < 12; i++) begin
      send(rxpw[i], err_at == i);
      s += rxpw[i];
    end
    send(8'h00 - s + delta, err_at == 12);
  endtask

  task automatic round(input int err_at, input logic [7:0] delta,
                       input logic [7:0] exp, input bit g, input string req);
    send(8'h10, 0);
    get_ack(8'h10, 0, "R2 echo");
    body(err_at, delta);
    get_ack(exp, g, req);
  endtask

  task automatic set_pw(input logic [7:0] base, input logic [7:0] step);
    for (int i = 0; i < 12; i++) begin
      mem[i] = base + step * 8'(i);
      rxpw[i] = mem[i];
    end
  endtask

  task automatic t_reset;
    chk(tx_valid === 0 && grant === 0 && pw_rd === 0, "R1 reset outputs",
        {5'd0, tx_valid, grant, pw_rd}, 8'h00);
    send(8'h37, 1);
    get_ack(8'h08, 0, "R1 R3 first error uses reset prev");
  endtask

  task automatic t_cmd_errors;
    send(8'h37, 0); get_ack(8'h31, 0, "R4 unknown cmd");
    send(8'h52, 1); get_ack(8'h38, 0, "R3 rx error cmd");
    send(8'h99, 0); get_ack(8'h51, 0, "R4 prev updates on error byte");
  endtask

  task automatic t_sync;
    sync_mode = 1;
    send(8'hA3, 1); get_ack(8'h91, 0, "R5 sync ignores cmd error");
    send(8'h10, 1); get_ack(8'h10, 0, "R5 sync accepts cmd");
    body(4, 8'h00); get_ack(8'h10, 1, "R5 sync ignores body error");
    sync_mode = 0;
  endtask

  task automatic t_good;
    round(-1, 8'h00, 8'h10, 1, "R10 success");
    send(8'h44, 0); get_ack(8'h11, 0, "R12 back to command wait");
  endtask

  task automatic t_checksum;
    round(-1, 8'h01, 8'h11, 0, "R6 bad checksum");
    send(8'h10, 1); get_ack(8'h18, 0, "R12 R3 after checksum fail");
  endtask

  task automatic t_priority;
    round(5, 8'h01, 8'h18, 0, "R7 rx error beats checksum");
    round(12, 8'h00, 8'h18, 0, "R7 rx error on checksum byte");
  endtask

  task automatic t_mismatch;
    rxpw[7] ^= 8'h01;
    round(-1, 8'h00, 8'h11, 0, "R8 password mismatch");
    rxpw[7] ^= 8'h01;
    rxpw[0] ^= 8'h80;
    round(-1, 8'h00, 8'h11, 0, "R8 first byte mismatch");
    rxpw[0] ^= 8'h80;
  endtask

  task automatic t_same;
    set_pw(8'h5A, 8'h00);
    round(-1, 8'h00, 8'h11, 0, "R9 repeated stored value");
    set_pw(8'hFF, 8'h00);
    round(-1, 8'h00, 8'h10, 1, "R9 blank store accepted");
    set_pw(8'hA0, 8'h07);
  endtask

  task automatic t_hold;
    send(8'h10, 0);
    @(negedge clk);
    rx_data = 8'h55; rx_valid = 1;
    repeat (3) @(negedge clk);
    chk(tx_valid === 1 && tx_data === 8'h10, "R11 ack held", tx_data, 8'h10);
    rx_valid = 0;
    get_ack(8'h10, 0, "R11 held ack");
    body(-1, 8'h00);
    get_ack(8'h10, 1, "R11 dropped bytes not counted");
  endtask

  initial begin
    set_pw(8'hA0, 8'h07);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_cmd_errors;
    t_sync;
    t_good;
    t_checksum;
    t_priority;
    t_mismatch;
    t_same;
    t_hold;
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule